// File: doc/BRIEF.md
# Auto-Negotiation Advertisement and Start Control

This block holds the advertised-ability word for one twisted-pair port and decides when link-pulse negotiation runs. At the first clock after reset it samples the hardware ability straps and the negotiation-enable strap. The sampled abilities become the starting advertisement and also a fixed ceiling. Software may later withdraw any allowed ability and restore it. It can never offer an ability that the straps left out.

The advertisement is presented as a 16-bit link code word for the pulse transmitter. Negotiation (FLP sending) starts on a power-on pulse, on a link-loss pulse or on a software restart, but only while negotiation is enabled. While sending, the block watches the incoming-burst detector. A detected partner moves it to a partner-seen state. If the phase timer runs out first, it hands over to parallel detection.

All pins are plain control and status. No data stream crosses the block edge, so there is no valid/ready back-pressure. The link code word is a level that stays stable until software changes the advertisement.

Top module: `an_adv_ctrl`

## Requirements
- R1: While reset is asserted, `lcw` is 0x0001 and `an_en`, `flp_sending`, `partner_seen` and `pdet_handoff` are 0. At the first rising edge after reset is released, `strap_abil` is captured as the ability mask and the advertisement, and `strap_an_en` is captured as `an_en`.
- R2: After capture, a write on `adv_wr` loads `adv_wdata & mask`. A bit whose strap was 0 stays 0. A bit whose strap was 1 can be cleared and restored.
- R3: `lcw` carries the selector value 00001 in bits 4:0 and the advertisement in bits 8:5 (bit 5 = 10 Mb/s half, bit 6 = 10 Mb/s full, bit 7 = 100 Mb/s half, bit 8 = 100 Mb/s full). Bits 15:9 are 0.
- R4: With `an_en` = 1, a one-cycle `power_on` or `link_lost` pulse makes `flp_sending` 1 after the next rising edge.
- R5: A control write with `ctl_an_en` = 1 and `ctl_restart` = 1 sets `restart_pend`. One edge later `flp_sending` is 1 and `restart_pend` has cleared itself. A restart written together with `ctl_an_en` = 0 is dropped.
- R6: While sending, `flp_seen` moves the block to `partner_seen` = 1 with `flp_sending` = 0 after the next edge.
- R7: While sending, `flp_timeout` without `flp_seen` gives `pdet_handoff` = 1 with `flp_sending` = 0 after the next edge.
- R8: A control write with `ctl_an_en` = 0 clears `an_en` and the three state outputs after that edge. While disabled, `power_on` and `link_lost` have no effect. Enabling again does not start sending by itself.
- R9: A start event in the sending, partner-seen or parallel-detect state returns the block to sending.
- R10: Changes on the strap inputs after capture do not change the mask or the advertisement.
- R11: A start event in the same cycle as `flp_seen` or `flp_timeout` wins, and the block stays in sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_abil | input | 4 | Hardware ability selects, sampled once after reset |
| strap_an_en | input | 1 | Hardware negotiation-enable select, sampled once after reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_an_en | input | 1 | Written negotiation-enable value |
| ctl_restart | input | 1 | Written restart request |
| adv_wr | input | 1 | Advertisement write strobe |
| adv_wdata | input | 4 | Written ability bits |
| power_on | input | 1 | Power-on event pulse |
| link_lost | input | 1 | Link-loss event pulse |
| flp_seen | input | 1 | Incoming burst detected from partner |
| flp_timeout | input | 1 | Sending phase timer expired |
| lcw | output | 16 | Link code word to transmit |
| an_en | output | 1 | Current negotiation enable |
| restart_pend | output | 1 | Restart request not yet taken |
| flp_sending | output | 1 | Block is sending link pulses |
| partner_seen | output | 1 | Partner bursts were detected |
| pdet_handoff | output | 1 | Control handed to parallel detection |

## Verification
A mask captured wrongly, or a masking term dropped, would show up in `lcw` one edge after the next advertisement write. The bench checks this with writes that try to set bits outside the mask. A wrong state transition or a wrong priority would show up in `flp_sending`, `partner_seen` or `pdet_handoff` one edge after the event that caused it. A restart flag that fails to clear would show up as `restart_pend` still being high one edge after sending begins.

// File: rtl/an_pkg.sv
package an_pkg;
  localparam int NUM_ABIL = 4;
  localparam int SEL_W    = 5;
  localparam int LCW_W    = 16;
  localparam int ABIL_LSB = SEL_W;
  localparam logic [SEL_W-1:0] SEL_CODE = 5'b00001;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_PART = 2'd2,
    ST_PDET = 2'd3
  } an_state_e;

  // Packs selector and ability bits into the transmitted word.
  function automatic logic [LCW_W-1:0] build_lcw(input logic [NUM_ABIL-1:0] abil);
    logic [LCW_W-1:0] w;
    w = '0;
    w[SEL_W-1:0] = SEL_CODE;
    w[ABIL_LSB +: NUM_ABIL] = abil;
    return w;
  endfunction
endpackage

// File: rtl/an_strap_latch.sv
module an_strap_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strap_abil,
  input  logic         strap_an_en,
  output logic         cap_pulse,
  output logic         captured,
  output logic [N-1:0] hw_mask,
  output logic         strap_en_q
);
  // The first clock after reset is the capture cycle.
  assign cap_pulse = !captured;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured   <= 1'b0;
      hw_mask    <= '0;
      strap_en_q <= 1'b0;
    end else if (cap_pulse) begin
      captured   <= 1'b1;
      hw_mask    <= strap_abil;
      strap_en_q <= strap_an_en;
    end
  end
endmodule

// File: rtl/an_adv_reg.sv
module an_adv_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_pulse,
  input  logic [N-1:0] strap_abil,
  input  logic [N-1:0] hw_mask,
  input  logic         adv_wr,
  input  logic [N-1:0] adv_wdata,
  output logic [N-1:0] adv
);
  // One cell per ability: loaded from the strap, then software can only lower it.
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        adv[i] <= 1'b0;
      else if (cap_pulse)
        adv[i] <= strap_abil[i];
      else if (adv_wr)
        adv[i] <= adv_wdata[i] & hw_mask[i];
    end
  end
endmodule

// File: rtl/an_ctl_reg.sv
module an_ctl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_pulse,
  input  logic strap_en,
  input  logic ctl_wr,
  input  logic ctl_an_en,
  input  logic ctl_restart,
  output logic an_en,
  output logic restart_pend,
  output logic disable_now
);
  logic wr_ok;
  assign wr_ok       = ctl_wr && !cap_pulse;
  assign disable_now = wr_ok && !ctl_an_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      an_en        <= 1'b0;
      restart_pend <= 1'b0;
    end else if (cap_pulse) begin
      an_en        <= strap_en;
      restart_pend <= 1'b0;
    end else if (wr_ok) begin
      an_en        <= ctl_an_en;
      restart_pend <= ctl_restart && ctl_an_en;
    end else if (restart_pend) begin
      // The start FSM takes the request at this edge, so the flag clears itself.
      restart_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/an_start_fsm.sv
module an_start_fsm
  import an_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic an_en,
  input  logic disable_now,
  input  logic power_on,
  input  logic link_lost,
  input  logic restart_pend,
  input  logic flp_seen,
  input  logic flp_timeout,
  output logic flp_sending,
  output logic partner_seen,
  output logic pdet_handoff
);
  an_state_e state_q, state_d;
  logic      start_evt;

  assign start_evt = power_on || link_lost || restart_pend;

  always_comb begin
    state_d = state_q;
    if (!an_en || disable_now) begin
      state_d = ST_IDLE;
    end else if (start_evt) begin
      state_d = ST_SEND;
    end else if (state_q == ST_SEND) begin
      if (flp_seen)
        state_d = ST_PART;
      else if (flp_timeout)
        state_d = ST_PDET;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign flp_sending  = (state_q == ST_SEND);
  assign partner_seen = (state_q == ST_PART);
  assign pdet_handoff = (state_q == ST_PDET);
endmodule

// File: rtl/an_adv_ctrl.sv
module an_adv_ctrl
  import an_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ABIL-1:0] strap_abil,
  input  logic                strap_an_en,
  input  logic                ctl_wr,
  input  logic                ctl_an_en,
  input  logic                ctl_restart,
  input  logic                adv_wr,
  input  logic [NUM_ABIL-1:0] adv_wdata,
  input  logic                power_on,
  input  logic                link_lost,
  input  logic                flp_seen,
  input  logic                flp_timeout,
  output logic [LCW_W-1:0]    lcw,
  output logic                an_en,
  output logic                restart_pend,
  output logic                flp_sending,
  output logic                partner_seen,
  output logic                pdet_handoff
);
  logic                cap_pulse;
  logic                captured;
  logic [NUM_ABIL-1:0] hw_mask;
  logic                strap_en_q;
  logic [NUM_ABIL-1:0] adv;
  logic                disable_now;

  an_strap_latch #(.N(NUM_ABIL)) u_strap (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_abil  (strap_abil),
    .strap_an_en (strap_an_en),
    .cap_pulse   (cap_pulse),
    .captured    (captured),
    .hw_mask     (hw_mask),
    .strap_en_q  (strap_en_q)
  );

  an_adv_reg #(.N(NUM_ABIL)) u_adv (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_pulse  (cap_pulse),
    .strap_abil (strap_abil),
    .hw_mask    (hw_mask),
    .adv_wr     (adv_wr),
    .adv_wdata  (adv_wdata),
    .adv        (adv)
  );

  an_ctl_reg u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_pulse    (cap_pulse),
    .strap_en     (strap_an_en),
    .ctl_wr       (ctl_wr),
    .ctl_an_en    (ctl_an_en),
    .ctl_restart  (ctl_restart),
    .an_en        (an_en),
    .restart_pend (restart_pend),
    .disable_now  (disable_now)
  );

  an_start_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .an_en        (an_en),
    .disable_now  (disable_now),
    .power_on     (power_on),
    .link_lost    (link_lost),
    .restart_pend (restart_pend),
    .flp_seen     (flp_seen),
    .flp_timeout  (flp_timeout),
    .flp_sending  (flp_sending),
    .partner_seen (partner_seen),
    .pdet_handoff (pdet_handoff)
  );

  assign lcw = build_lcw(adv);
endmodule

// File: rtl/an_adv_ctrl_chk.sv
module an_adv_ctrl_chk
  import an_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                captured,
  input logic [NUM_ABIL-1:0] hw_mask,
  input logic [LCW_W-1:0]    lcw,
  input logic                ctl_wr,
  input logic                power_on,
  input logic                link_lost,
  input logic                flp_seen,
  input logic                flp_timeout,
  input logic                an_en,
  input logic                restart_pend,
  input logic                flp_sending,
  input logic                partner_seen,
  input logic                pdet_handoff
);
  logic start_evt;
  assign start_evt = power_on || link_lost || restart_pend;

  AST_ADV_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    captured |-> ((lcw[ABIL_LSB +: NUM_ABIL] & ~hw_mask) == '0)); // R2

  AST_EVENT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (an_en && (power_on || link_lost) && !ctl_wr) |=> flp_sending); // R4

  AST_RESTART_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_pend && an_en && !ctl_wr) |=> (!restart_pend && flp_sending)); // R5

  AST_SEEN_TO_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
    (flp_sending && flp_seen && !start_evt && !ctl_wr) |=> partner_seen); // R6

  AST_TIMEOUT_TO_PDET: assert property (@(posedge clk) disable iff (!rst_n)
    (flp_sending && flp_timeout && !flp_seen && !start_evt && !ctl_wr) |=> pdet_handoff); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !an_en |-> !(flp_sending || partner_seen || pdet_handoff)); // R8

  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> $stable(hw_mask)); // R10

  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (an_en && start_evt && !ctl_wr) |=> (flp_sending && !partner_seen && !pdet_handoff)); // R11
endmodule

bind an_adv_ctrl an_adv_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .captured     (captured),
  .hw_mask      (hw_mask),
  .lcw          (lcw),
  .ctl_wr       (ctl_wr),
  .power_on     (power_on),
  .link_lost    (link_lost),
  .flp_seen     (flp_seen),
  .flp_timeout  (flp_timeout),
  .an_en        (an_en),
  .restart_pend (restart_pend),
  .flp_sending  (flp_sending),
  .partner_seen (partner_seen),
  .pdet_handoff (pdet_handoff)
);

// File: tb/an_adv_ctrl_test.sv
`timescale 1ns/1ps
module an_adv_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap_abil = 4'b1011;
  logic        strap_an_en = 1'b1;
  logic        ctl_wr = 0, ctl_an_en = 0, ctl_restart = 0;
  logic        adv_wr = 0;
  logic [3:0]  adv_wdata = 0;
  logic        power_on = 0, link_lost = 0, flp_seen = 0, flp_timeout = 0;
  logic [15:0] lcw;
  logic        an_en, restart_pend, flp_sending, partner_seen, pdet_handoff;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  an_adv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .strap_abil(strap_abil), .strap_an_en(strap_an_en),
    .ctl_wr(ctl_wr), .ctl_an_en(ctl_an_en), .ctl_restart(ctl_restart),
    .adv_wr(adv_wr), .adv_wdata(adv_wdata), .power_on(power_on),
    .link_lost(link_lost), .flp_seen(flp_seen), .flp_timeout(flp_timeout),
    .lcw(lcw), .an_en(an_en), .restart_pend(restart_pend),
    .flp_sending(flp_sending), .partner_seen(partner_seen), .pdet_handoff(pdet_handoff)
  );

  // Advertisement writes under strap mask 1011: {write value, expected word}.
  localparam logic [19:0] VEC [8] = '{
    {4'b0000, 16'h0001}, {4'b1111, 16'h0161}, {4'b0100, 16'h0001},
    {4'b0011, 16'h0061}, {4'b1000, 16'h0101}, {4'b1011, 16'h0161},
    {4'b0001, 16'h0021}, {4'b1110, 16'h0141}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // State outputs packed as {sending, partner, pdet}.
  function automatic logic [15:0] st();
    return {13'd0, flp_sending, partner_seen, pdet_handoff};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_in();
    ctl_wr = 0; ctl_an_en = 0; ctl_restart = 0; adv_wr = 0;
    power_on = 0; link_lost = 0; flp_seen = 0; flp_timeout = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset values
    chk("R1 reset lcw", lcw, 16'h0001);
    chk("R1 reset state", {15'd0, an_en} | st(), 16'h0000);
    rst_n = 1'b1;
    tick();
    chk("R1 captured adv", lcw, 16'h0161);
    chk("R1 captured enable", {15'd0, an_en}, 16'h0001);
    chk("R1 no auto start", st(), 16'h0000);

    // R2 R3 advertisement table
    foreach (VEC[i]) begin
      adv_wr = 1; adv_wdata = VEC[i][19:16];
      tick();
      adv_wr = 0;
      chk("R2 R3 masked advertisement", lcw, VEC[i][15:0]);
    end

    // R10 strap changes ignored
    strap_abil = 4'b0100; strap_an_en = 1'b0;
    adv_wr = 1; adv_wdata = 4'b1111;
    tick(); adv_wr = 0;
    chk("R10 strap ignored", lcw, 16'h0161);
    chk("R10 enable kept", {15'd0, an_en}, 16'h0001);

    // R4 power_on, then R7 timeout
    power_on = 1; tick(); power_on = 0;
    chk("R4 power_on starts", st(), 16'h0004);
    tick();
    chk("R4 still sending", st(), 16'h0004);
    flp_timeout = 1; tick(); flp_timeout = 0;
    chk("R7 timeout to pdet", st(), 16'h0001);
    // R9 from pdet via link_lost (also R4)
    link_lost = 1; tick(); link_lost = 0;
    chk("R9 R4 link_lost restarts", st(), 16'h0004);
    // R11 event beats flp_seen
    link_lost = 1; flp_seen = 1; tick(); clear_in();
    chk("R11 start wins over seen", st(), 16'h0004);
    power_on = 1; flp_timeout = 1; tick(); clear_in();
    chk("R11 start wins over timeout", st(), 16'h0004);
    // R6 partner seen
    flp_seen = 1; tick(); flp_seen = 0;
    chk("R6 seen to partner", st(), 16'h0002);
    // R5 restart from partner state (R9)
    ctl_wr = 1; ctl_an_en = 1; ctl_restart = 1; tick(); clear_in();
    chk("R5 restart pending", {15'd0, restart_pend}, 16'h0001);
    chk("R9 partner held before restart", st(), 16'h0002);
    tick();
    chk("R5 restart cleared", {15'd0, restart_pend}, 16'h0000);
    chk("R5 R9 restart sends", st(), 16'h0004);

    // R8 disable
    ctl_wr = 1; ctl_an_en = 0; tick(); clear_in();
    chk("R8 enable cleared", {15'd0, an_en}, 16'h0000);
    chk("R8 quiet", st(), 16'h0000);
    power_on = 1; tick(); power_on = 0;
    chk("R8 power_on ignored", st(), 16'h0000);
    link_lost = 1; tick(); link_lost = 0;
    chk("R8 link_lost ignored", st(), 16'h0000);
    ctl_wr = 1; ctl_an_en = 0; ctl_restart = 1; tick(); clear_in();
    chk("R5 restart dropped when disabled", {15'd0, restart_pend}, 16'h0000);
    tick();
    chk("R5 no sending after dropped restart", st(), 16'h0000);
    ctl_wr = 1; ctl_an_en = 1; tick(); clear_in();
    chk("R8 re-enable", {15'd0, an_en}, 16'h0001);
    tick();
    chk("R8 no auto start on enable", st(), 16'h0000);

    // R1 second reset with other straps
    rst_n = 0; strap_abil = 4'b0101; strap_an_en = 1'b0;
    tick(); tick();
    chk("R1 reset again state", st(), 16'h0000);
    rst_n = 1; tick();
    chk("R1 R3 captured second mask", lcw, 16'h00A1);
    chk("R1 strap disable", {15'd0, an_en}, 16'h0000);
    power_on = 1; tick(); power_on = 0;
    chk("R8 strap-disabled ignores power_on", st(), 16'h0000);
    adv_wr = 1; adv_wdata = 4'b1010; tick(); adv_wr = 0;
    chk("R2 masked to zero", lcw, 16'h0001);
    adv_wr = 1; adv_wdata = 4'b0100; tick(); adv_wr = 0;
    chk("R2 restore allowed bit", lcw, 16'h0081);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule